// File: doc/BRIEF.md
# MSI interrupt request handler

This block sits between application logic that raises interrupts and the transmit side of a PCI Express endpoint. When the application holds its request line high, the block checks the current interrupt mode. In MSI mode it sends one single-dword posted memory write as a sequence of 32-bit beats on a valid/ready transmit port, and it pulses the acknowledge output when the last beat is taken. The write address and data come from the MSI capability registers. The vector number and traffic class given with the request are folded into the packet.

The block keeps track of which interrupt scheme is active. After reset it starts in legacy INTx mode. Legacy, MSI and MSI-X signalling never overlap, and MSI-X generation is handled elsewhere. In legacy mode, each edge of the application's level-sensitive interrupt status becomes a one-cycle assert or deassert message request. The command register's interrupt-disable bit blocks these message requests. A request made while MSI is not the active mode is acknowledged without sending anything, and a drop flag marks it.

Top module: `msi_req_handler`

## Requirements
- R1: While reset is applied and in the first cycle after it is released, the mode output reads INTx (code 0) and `tx_valid_o`, `irq_ack_o`, `drop_o` and `lgcy_msg_valid_o` are all low.
- R2: `irq_mode_o` follows the configuration one cycle after it changes. The MSI enable is bit 0 of `msi_ctl_i`. The codes are: neither MSI nor MSI-X enabled gives 0 (INTx); MSI enabled alone gives 1 (MSI); MSI-X enabled alone gives 2 (MSI-X); both enabled gives 3 (off).
- R3: Every request accepted in MSI mode produces exactly one packet. `irq_ack_o` is high for exactly one cycle: the cycle in which the final beat is transferred (`tx_valid_o`, `tx_ready_i` and `tx_last_o` all high). The request line is sampled again only after that acknowledge.
- R4: Beat 0 is the header dword: bits 31:29 are the format (3'b010 for a 3-dword header, 3'b011 for a 4-dword header), bits 28:24 are 0, bits 22:20 carry the traffic class, bits 9:0 carry length 1, and all other bits are 0. Beat 1 is 32'h0000000F.
- R5: A 4-dword header is used only when the 64-bit capable bit (bit 7 of `msi_ctl_i`) is set and `msi_addr_hi_i` is nonzero. In that case beat 2 is the upper address and beat 3 is the lower address. Otherwise beat 2 is the lower address. In both cases bits 1:0 of the lower address are sent as zero.
- R6: The final beat is the payload {16'h0, data}. In `data`, the low n bits of the message data are replaced by the low n bits of the vector number. n is the multiple-message-enable field (bits 6:4 of `msi_ctl_i`), limited to at most 5.
- R7: Traffic class, vector, message data, address and control values are captured in the cycle the request is accepted. Changes to them while the packet is being sent do not alter the packet.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, the next cycle keeps `tx_valid_o` high and keeps `tx_data_o` and `tx_last_o` unchanged.
- R9: A request seen when the registered mode is not MSI produces no beat. In the following cycle, `irq_ack_o` and `drop_o` are both high for exactly one cycle.
- R10: In INTx mode, the cycle after `lgcy_sts_i` rises, `lgcy_msg_valid_o` pulses with `lgcy_msg_assert_o` = 1. The cycle after it falls, the pulse carries `lgcy_msg_assert_o` = 0.
- R11: No legacy message pulse occurs while `intx_dis_i` is 1 or while the mode is not INTx.
- R12: `tx_last_o` is high only on the final beat. A packet has 4 beats with a 3-dword header and 5 beats with a 4-dword header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req_i | input | 1 | Interrupt request, held until acknowledged |
| irq_ack_o | output | 1 | One-cycle acknowledge of the request |
| irq_tc_i | input | 3 | Traffic class for the message write |
| irq_vec_i | input | 5 | Vector number folded into the message data |
| lgcy_sts_i | input | 1 | Level-sensitive legacy interrupt status |
| msi_ctl_i | input | 16 | MSI message control view (bit 0 enable, bits 6:4 granted vectors, bit 7 64-bit capable) |
| msix_en_i | input | 1 | MSI-X enable from configuration space |
| intx_dis_i | input | 1 | Command register interrupt-disable bit |
| msi_addr_lo_i | input | 32 | MSI message address, lower dword |
| msi_addr_hi_i | input | 32 | MSI message address, upper dword |
| msi_data_i | input | 16 | MSI message data |
| tx_valid_o | output | 1 | Transmit beat valid |
| tx_ready_i | input | 1 | Transmit beat accepted |
| tx_data_o | output | 32 | Transmit beat dword |
| tx_last_o | output | 1 | Final beat of the packet |
| drop_o | output | 1 | One-cycle flag: request acknowledged without a packet |
| lgcy_msg_valid_o | output | 1 | One-cycle legacy message request |
| lgcy_msg_assert_o | output | 1 | 1 = assert message, 0 = deassert message |
| irq_mode_o | output | 2 | Active interrupt mode code |

## Verification
A wrong mode register shows up at the ports within one cycle as an incorrect mode code. It also shows up as a dropped request where a packet was expected, or as a legacy pulse in a mode that forbids it. A wrong beat index or a wrong header-size decision changes a dword or moves the last marker. The reference model spots this on the first transferred beat that differs. Missing capture shows only while a packet is in flight, so requests are made with back-pressure and with inputs changed mid-packet. A stuck state register leaves the acknowledge missing, and the per-request wait bound turns that into a failure.

// File: rtl/msi_irq_pkg.sv
package msi_irq_pkg;

    localparam int TC_W       = 3;
    localparam int VEC_W      = 5;
    localparam int DW_W       = 32;
    localparam int MSG_W      = 16;
    localparam int CTL_W      = 16;
    localparam int MAX_BEATS  = 5;
    localparam int BEAT_IDX_W = $clog2(MAX_BEATS);

    // bit positions inside the message control view
    localparam int CTL_EN_BIT  = 0;
    localparam int CTL_MME_LSB = 4;
    localparam int CTL_MME_W   = 3;
    localparam int CTL_A64_BIT = 7;

    localparam logic [CTL_MME_W-1:0] MME_LIMIT = CTL_MME_W'(VEC_W);

    typedef enum logic [1:0] {
        MODE_INTX = 2'd0,
        MODE_MSI  = 2'd1,
        MODE_MSIX = 2'd2,
        MODE_OFF  = 2'd3
    } irq_mode_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_SEND = 2'd1,
        TX_DROP = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic                 wide;
        logic [TC_W-1:0]      tc;
        logic [VEC_W-1:0]     vec;
        logic [CTL_MME_W-1:0] mme;
        logic [DW_W-1:0]      addr_hi;
        logic [DW_W-1:0]      addr_lo;
        logic [MSG_W-1:0]     data;
    } msi_req_t;

    // replace the granted low bits of the message data with the vector
    function automatic logic [MSG_W-1:0] vec_merge(
        input logic [MSG_W-1:0]     d,
        input logic [VEC_W-1:0]     v,
        input logic [CTL_MME_W-1:0] mme
    );
        logic [CTL_MME_W-1:0] n;
        logic [MSG_W-1:0]     m;
        n = (mme > MME_LIMIT) ? MME_LIMIT : mme;
        m = '0;
        for (int i = 0; i < VEC_W; i++) begin
            if (CTL_MME_W'(i) < n) m[i] = 1'b1;
        end
        return (d & ~m) | (MSG_W'(v) & m);
    endfunction

    // first header dword of a memory write carrying one data dword
    function automatic logic [DW_W-1:0] hdr_dw0(
        input logic [TC_W-1:0] tc,
        input logic            wide
    );
        logic [2:0] fmt;
        fmt = wide ? 3'b011 : 3'b010;
        return {fmt, 5'b00000, 1'b0, tc, 10'd0, 10'd1};
    endfunction

endpackage

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
    import msi_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      msi_en_i,
    input  logic      msix_en_i,
    input  logic      intx_dis_i,
    input  logic      lgcy_sts_i,
    output irq_mode_e mode_o,
    output logic      lgcy_valid_o,
    output logic      lgcy_assert_o
);

    irq_mode_e mode_q;
    irq_mode_e mode_d;
    logic      sts_q;
    logic      lv_q;
    logic      la_q;

    always_comb begin
        unique case ({msix_en_i, msi_en_i})
            2'b00:   mode_d = MODE_INTX;
            2'b01:   mode_d = MODE_MSI;
            2'b10:   mode_d = MODE_MSIX;
            default: mode_d = MODE_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_INTX;
            sts_q  <= 1'b0;
            lv_q   <= 1'b0;
            la_q   <= 1'b0;
        end else begin
            mode_q <= mode_d;
            sts_q  <= lgcy_sts_i;
            lv_q   <= (lgcy_sts_i != sts_q) && (mode_q == MODE_INTX) && !intx_dis_i;
            la_q   <= lgcy_sts_i;
        end
    end

    assign mode_o        = mode_q;
    assign lgcy_valid_o  = lv_q;
    assign lgcy_assert_o = la_q;

    AST_LGCY_EDGE: assert property (@(posedge clk) disable iff (rst)
        lgcy_valid_o |-> (lgcy_assert_o != $past(sts_q))); // R10

endmodule

// File: rtl/msi_beat_fmt.sv
module msi_beat_fmt
    import msi_irq_pkg::*;
(
    input  msi_req_t              req_i,
    input  logic [BEAT_IDX_W-1:0] idx_i,
    output logic [DW_W-1:0]       beat_o,
    output logic                  last_o
);

    localparam logic [BEAT_IDX_W-1:0] LAST_WIDE   = BEAT_IDX_W'(MAX_BEATS - 1);
    localparam logic [BEAT_IDX_W-1:0] LAST_NARROW = BEAT_IDX_W'(MAX_BEATS - 2);

    logic [DW_W-1:0] beats [MAX_BEATS];
    logic [DW_W-1:0] addr32;
    logic [DW_W-1:0] payload;
    logic            unused_lo;

    assign addr32    = {req_i.addr_lo[DW_W-1:2], 2'b00};
    assign payload   = {{(DW_W-MSG_W){1'b0}}, vec_merge(req_i.data, req_i.vec, req_i.mme)};
    assign unused_lo = ^req_i.addr_lo[1:0];

    always_comb begin
        beats[0] = hdr_dw0(req_i.tc, req_i.wide);
        beats[1] = 32'h0000_000F;
        if (req_i.wide) begin
            beats[2] = req_i.addr_hi;
            beats[3] = addr32;
            beats[4] = payload;
        end else begin
            beats[2] = addr32;
            beats[3] = payload;
            beats[4] = '0;
        end
    end

    assign beat_o = beats[idx_i];
    assign last_o = (idx_i == (req_i.wide ? LAST_WIDE : LAST_NARROW));

endmodule

// File: rtl/msi_tx_fsm.sv
module msi_tx_fsm
    import msi_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_i,
    input  logic [TC_W-1:0]      tc_i,
    input  logic [VEC_W-1:0]     vec_i,
    input  irq_mode_e            mode_i,
    input  logic                 a64_i,
    input  logic [CTL_MME_W-1:0] mme_i,
    input  logic [DW_W-1:0]      addr_lo_i,
    input  logic [DW_W-1:0]      addr_hi_i,
    input  logic [MSG_W-1:0]     data_i,
    input  logic                 tx_ready_i,
    output logic                 tx_valid_o,
    output logic [DW_W-1:0]      tx_data_o,
    output logic                 tx_last_o,
    output logic                 ack_o,
    output logic                 drop_o
);

    tx_state_e             st_q;
    logic [BEAT_IDX_W-1:0] idx_q;
    msi_req_t              req_q;
    msi_req_t              cap;
    logic                  last;

    always_comb begin
        cap.wide    = a64_i && (addr_hi_i != '0);
        cap.tc      = tc_i;
        cap.vec     = vec_i;
        cap.mme     = mme_i;
        cap.addr_hi = addr_hi_i;
        cap.addr_lo = addr_lo_i;
        cap.data    = data_i;
    end

    msi_beat_fmt u_fmt (
        .req_i  (req_q),
        .idx_i  (idx_q),
        .beat_o (tx_data_o),
        .last_o (last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TX_IDLE;
            idx_q <= '0;
            req_q <= '0;
        end else begin
            unique case (st_q)
                TX_IDLE: begin
                    if (req_i) begin
                        if (mode_i == MODE_MSI) begin
                            req_q <= cap;
                            idx_q <= '0;
                            st_q  <= TX_SEND;
                        end else begin
                            st_q  <= TX_DROP;
                        end
                    end
                end
                TX_SEND: begin
                    if (tx_ready_i) begin
                        if (last) st_q  <= TX_IDLE;
                        else      idx_q <= idx_q + BEAT_IDX_W'(1);
                    end
                end
                default: st_q <= TX_IDLE;
            endcase
        end
    end

    assign tx_valid_o = (st_q == TX_SEND);
    assign tx_last_o  = tx_valid_o && last;
    assign drop_o     = (st_q == TX_DROP);
    assign ack_o      = (tx_valid_o && tx_ready_i && last) || drop_o;

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o) && $stable(tx_last_o))); // R8

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o); // R3

    AST_PKT_END: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && tx_ready_i && tx_last_o) |=> !tx_valid_o); // R3

    AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
        drop_o |-> (!tx_valid_o && ack_o)); // R9

    AST_NO_TX_OUTSIDE_MSI: assert property (@(posedge clk) disable iff (rst)
        (st_q == TX_IDLE && req_i && mode_i != MODE_MSI) |=> !tx_valid_o); // R9

endmodule

// File: rtl/msi_req_handler.sv
module msi_req_handler
    import msi_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req_i,
    output logic              irq_ack_o,
    input  logic [TC_W-1:0]   irq_tc_i,
    input  logic [VEC_W-1:0]  irq_vec_i,
    input  logic              lgcy_sts_i,
    input  logic [CTL_W-1:0]  msi_ctl_i,
    input  logic              msix_en_i,
    input  logic              intx_dis_i,
    input  logic [DW_W-1:0]   msi_addr_lo_i,
    input  logic [DW_W-1:0]   msi_addr_hi_i,
    input  logic [MSG_W-1:0]  msi_data_i,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic [DW_W-1:0]   tx_data_o,
    output logic              tx_last_o,
    output logic              drop_o,
    output logic              lgcy_msg_valid_o,
    output logic              lgcy_msg_assert_o,
    output logic [1:0]        irq_mode_o
);

    irq_mode_e mode;
    logic      unused_ctl;

    assign unused_ctl = ^{msi_ctl_i[CTL_W-1:CTL_A64_BIT+1],
                          msi_ctl_i[CTL_MME_LSB-1:CTL_EN_BIT+1]};

    irq_mode_ctrl u_mode (
        .clk           (clk),
        .rst           (rst),
        .msi_en_i      (msi_ctl_i[CTL_EN_BIT]),
        .msix_en_i     (msix_en_i),
        .intx_dis_i    (intx_dis_i),
        .lgcy_sts_i    (lgcy_sts_i),
        .mode_o        (mode),
        .lgcy_valid_o  (lgcy_msg_valid_o),
        .lgcy_assert_o (lgcy_msg_assert_o)
    );

    msi_tx_fsm u_tx (
        .clk        (clk),
        .rst        (rst),
        .req_i      (irq_req_i),
        .tc_i       (irq_tc_i),
        .vec_i      (irq_vec_i),
        .mode_i     (mode),
        .a64_i      (msi_ctl_i[CTL_A64_BIT]),
        .mme_i      (msi_ctl_i[CTL_MME_LSB +: CTL_MME_W]),
        .addr_lo_i  (msi_addr_lo_i),
        .addr_hi_i  (msi_addr_hi_i),
        .data_i     (msi_data_i),
        .tx_ready_i (tx_ready_i),
        .tx_valid_o (tx_valid_o),
        .tx_data_o  (tx_data_o),
        .tx_last_o  (tx_last_o),
        .ack_o      (irq_ack_o),
        .drop_o     (drop_o)
    );

    assign irq_mode_o = mode;

    AST_LGCY_ONLY_INTX: assert property (@(posedge clk) disable iff (rst)
        lgcy_msg_valid_o |-> $past(irq_mode_o == 2'd0 && !intx_dis_i)); // R11

endmodule

// File: tb/msi_req_handler_tb.sv
module msi_req_handler_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic        irq_ack;
    logic [2:0]  irq_tc = '0;
    logic [4:0]  irq_vec = '0;
    logic        lgcy_sts = 1'b0;
    logic [15:0] msi_ctl = '0;
    logic        msix_en = 1'b0;
    logic        intx_dis = 1'b0;
    logic [31:0] addr_lo = '0;
    logic [31:0] addr_hi = '0;
    logic [15:0] msi_data = '0;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [31:0] tx_data;
    logic        tx_last;
    logic        drop;
    logic        lv;
    logic        la;
    logic [1:0]  mode;

    always #10 clk = ~clk;

    msi_req_handler dut_i (
        .clk(clk), .rst(rst), .irq_req_i(irq_req), .irq_ack_o(irq_ack),
        .irq_tc_i(irq_tc), .irq_vec_i(irq_vec), .lgcy_sts_i(lgcy_sts),
        .msi_ctl_i(msi_ctl), .msix_en_i(msix_en), .intx_dis_i(intx_dis),
        .msi_addr_lo_i(addr_lo), .msi_addr_hi_i(addr_hi), .msi_data_i(msi_data),
        .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
        .tx_last_o(tx_last), .drop_o(drop), .lgcy_msg_valid_o(lv),
        .lgcy_msg_assert_o(la), .irq_mode_o(mode)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_req = 0;
    int n_ack = 0;
    int cyc = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    bit rand_ready = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_mode, m_st, m_idx;
    logic        m_prev, m_lv, m_la, m_wide;
    logic [31:0] m_q[$];
    int unsigned m_n, m_pw, m_d, m_pay;

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 0; m_prev = 0; m_lv = 0; m_la = 0;
            m_st = 0; m_idx = 0; m_q.delete();
        end else begin
            m_lv = (lgcy_sts != m_prev) && (m_mode == 0) && !intx_dis;
            m_la = lgcy_sts;
            m_prev = lgcy_sts;
            case (m_st)
                0: if (irq_req) begin
                    if (m_mode == 1) begin
                        m_wide = msi_ctl[7] && (addr_hi != 0);
                        m_n = msi_ctl[6:4];
                        if (m_n > 5) m_n = 5;
                        m_pw = 1 << m_n;
                        m_d = msi_data;
                        m_pay = m_d - (m_d % m_pw) + (irq_vec % m_pw);
                        m_q.delete();
                        m_q.push_back(((m_wide ? 32'd3 : 32'd2) << 29) | (32'(irq_tc) << 20) | 32'd1);
                        m_q.push_back(32'h0000_000F);
                        if (m_wide) m_q.push_back(addr_hi);
                        m_q.push_back(addr_lo & 32'hFFFF_FFFC);
                        m_q.push_back(m_pay);
                        m_st = 1; m_idx = 0;
                    end else m_st = 2;
                end
                1: if (tx_ready) begin
                    if (m_idx == m_q.size() - 1) m_st = 0;
                    else m_idx++;
                end
                default: m_st = 0;
            endcase
            m_mode = msix_en ? (msi_ctl[0] ? 3 : 2) : (msi_ctl[0] ? 1 : 0);
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (checking && !done) begin
            logic exp_v, exp_last, exp_ack;
            exp_v    = (m_st == 1);
            exp_last = exp_v && (m_idx == m_q.size() - 1);
            exp_ack  = (exp_v && tx_ready && exp_last) || (m_st == 2);
            chk("R2 mode", 32'(mode), 32'(m_mode));
            chk("R10 R11 legacy pulse", 32'(lv), 32'(m_lv));
            if (m_lv) chk("R10 legacy polarity", 32'(la), 32'(m_la));
            chk("R3 R8 tx_valid", 32'(tx_valid), 32'(exp_v));
            if (exp_v) begin
                if (m_idx < 2)                   chk("R4 header beat", tx_data, m_q[m_idx]);
                else if (m_idx == m_q.size() - 1) chk("R6 R7 payload beat", tx_data, m_q[m_idx]);
                else                             chk("R5 address beat", tx_data, m_q[m_idx]);
                chk("R12 tx_last", 32'(tx_last), 32'(exp_last));
            end
            chk("R3 ack", 32'(irq_ack), 32'(exp_ack));
            chk("R9 drop", 32'(drop), 32'(m_st == 2));
            if (irq_ack) n_ack++;
        end
    end

    always @(posedge clk) begin
        #2;
        if (rand_ready) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            tx_ready = lfsr[0];
        end else tx_ready = 1'b1;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL R3 watchdog actual=%0d cycles expected<=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic step(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic do_req(logic [2:0] tc, logic [4:0] vec, bit mutate);
        bit got;
        step(1);
        irq_req = 1'b1; irq_tc = tc; irq_vec = vec;
        n_req++;
        got = 1'b0;
        for (int i = 0; i < 200 && !got; i++) begin
            @(negedge clk);
            if (irq_ack) got = 1'b1;
            else if (mutate && i == 1) begin
                #1;
                irq_tc = ~tc; irq_vec = ~vec; msi_data = ~msi_data; addr_lo = ~addr_lo;
            end
        end
        if (!got) begin
            n_chk++; n_fail++;
            $display("FAIL R3 no acknowledge actual=0 expected=1");
        end
        step(1);
        irq_req = 1'b0;
        if (mutate) begin msi_data = ~msi_data; addr_lo = ~addr_lo; end
        step(2);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        checking = 1'b1;
        @(negedge clk);
        chk("R1 reset mode", 32'(mode), 32'd0);
        chk("R1 reset tx_valid", 32'(tx_valid), 32'd0);
        chk("R1 reset ack", 32'(irq_ack), 32'd0);
        chk("R1 reset drop", 32'(drop), 32'd0);
        chk("R1 reset legacy", 32'(lv), 32'd0);

        // R10: legacy edges in INTx mode
        step(1); lgcy_sts = 1'b1; step(3);
        lgcy_sts = 1'b0; step(3);
        // R11: interrupt disable suppresses legacy messages
        intx_dis = 1'b1; step(1);
        lgcy_sts = 1'b1; step(3); lgcy_sts = 1'b0; step(3);
        // R9: request outside MSI mode
        do_req(3'd1, 5'd4, 1'b0);

        // R2 R4 R5 R6: MSI, 32-bit address, two granted vector bits
        msi_ctl = 16'h0021; addr_lo = 32'hFEE0_1003; addr_hi = 32'h0000_1234;
        msi_data = 16'hABCD; step(2);
        do_req(3'd5, 5'd3, 1'b0);
        // R5 R6 R7 R8: 64-bit address, limit on vector bits, back-pressure, mid-packet changes
        msi_ctl = 16'h00F1; rand_ready = 1'b1; step(2);
        do_req(3'd2, 5'd31, 1'b1);
        // R5: 64-bit capable but upper address zero
        addr_hi = 32'h0; msi_data = 16'h5A5F; step(2);
        do_req(3'd7, 5'h16, 1'b0);
        msi_ctl = 16'h0031; addr_hi = 32'h8000_0000; step(2);
        do_req(3'd0, 5'd9, 1'b1);
        rand_ready = 1'b0;

        // R11: legacy edge in MSI mode with disable clear
        intx_dis = 1'b0; step(1);
        lgcy_sts = 1'b1; step(3); lgcy_sts = 1'b0; step(3);

        // R2 R9: both enables set, then MSI-X alone
        msix_en = 1'b1; step(2);
        do_req(3'd3, 5'd1, 1'b0);
        msi_ctl = 16'h0000; step(2);
        do_req(3'd4, 5'd2, 1'b0);
        // back to INTx, R10 again
        msix_en = 1'b0; step(2);
        lgcy_sts = 1'b1; step(3); lgcy_sts = 1'b0; step(3);

        @(negedge clk);
        chk("R3 one ack per request", 32'(n_ack), 32'(n_req));
        finish_run();
    end

endmodule